// File: doc/BRIEF.md
# Shared-Source Interrupt Acceptance Controller

This block decides when a small 8-bit processor core should take an interrupt. Each source has a request latch and an enable bit. A global disable flag, held here for the core, masks every request except the software break. Events arrive as raw pulses or pin levels: two external pins with a selectable edge, a key-on wakeup built from three port pins, a bus-collision pulse, a conversion-done pulse and a timer pulse. The block raises `irq_o` together with the index of the winning source. When the core returns an acknowledge, the block clears that source's request bit and sets the disable flag.

Two request bits are shared by two sources each. Request bit 2 is shared by key-on wakeup and bus collision. Request bit 3 is shared by conversion-done and timer. Each of these four sources has its own valid bit, which decides whether its event reaches the shared request bit. Each also has its own discrimination bit, which records that the event happened whether or not the source is valid. Software uses the discrimination bits to tell the two sources of a shared request apart. A small register port gives access to requests, enables, valid bits, discrimination bits and the edge/key configuration.

The core drives strobes for set-disable, clear-disable, break and return-from-interrupt. The return strobe carries the disable-flag value the core restored from its stack.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, all request, enable, valid, discrimination and configuration registers read 0, `iflag_o` is 1 and `irq_o` is 0.
- R2: `irq_o` is 1 exactly when some request bit and its enable bit are both 1 and `iflag_o` is 0. `irq_id_o` is the lowest index among requests that are pending and enabled, or 0 when there is none.
- R3: An `ack_i` in a cycle with `irq_o`=1 sets `iflag_o` to 1 in the next cycle and clears only the selected request bit. `iflag_o` is still 0 during the acknowledge cycle, so the core saves the flag as 0.
- R4: At address 0 the request bits sit at [3:0]: bits 0 and 1 are the external pins, bit 2 is key wakeup/collision, bit 3 is conversion/timer. Writing 0 to a bit clears it. Writing 1 has no effect.
- R5: At address 1 the enable bits are read/write, one per request bit. A source whose enable bit is 0 still sets its request bit but does not raise `irq_o`.
- R6: At address 2 the valid bits are read/write: bit0 key wakeup, bit1 collision, bit2 conversion, bit3 timer. An event from a valid source sets its shared request bit. An event from an invalid source does not.
- R7: At address 3 the discrimination bits use the same layout as the valid bits. Each goes to 1 on its source's event regardless of the valid bit. A software write of 0 clears a bit; a write of 1 has no effect.
- R8: At address 4, bits [1:0] pick the edge for external pins 0 and 1: 1 means rising, 0 means falling. Each pin passes through a two-flop synchronizer before edge detection, and the opposite edge is ignored.
- R9: At address 4, bits [4:2] enable key-on wakeup for key pins 0 to 2. A falling edge on an enabled key pin is a key-wakeup event. Edges on pins that are not enabled are ignored.
- R10: `brk_i` sets `iflag_o` whatever its state, and `sei_i`/`cli_i` set and clear it. `rti_i` loads `rti_flag_i`. When strobes coincide, acknowledge or break wins over return, return wins over set, and set wins over clear.
- R11: A hardware event that sets a request bit wins over a software clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_i | input | N_EXT | External interrupt pins, asynchronous |
| key_pin_i | input | N_KEY | Key-on wakeup port pins, asynchronous |
| col_evt_i | input | 1 | Bus-collision event pulse |
| adc_evt_i | input | 1 | Conversion-done event pulse |
| tmr_evt_i | input | 1 | Timer event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational |
| ack_i | input | 1 | Core accepts the pending interrupt |
| brk_i | input | 1 | Core executes a software break |
| rti_i | input | 1 | Core returns from interrupt |
| rti_flag_i | input | 1 | Disable-flag value restored by the return |
| sei_i | input | 1 | Set the disable flag |
| cli_i | input | 1 | Clear the disable flag |
| irq_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | ID_W | Index of the selected source |
| iflag_o | output | 1 | Current disable flag |

## Verification
The assertions check on every cycle the following:
- No request or discrimination bit rises without a hardware event behind it.
- An accepted request bit drops after the acknowledge.
- An acknowledge or a break leaves the disable flag set.
- A return loads the flag value supplied with it.

Only the bench scenarios can show the rest:
- The register map and the write-0-only behaviour.
- Edge selection through the synchronizer.
- Which key pins are enabled.
- Priority among several pending sources.
- The valid/discrimination split on the shared request bits.
- A hardware set beating a same-cycle software clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W       = 3;
   localparam int SHARED_PAIRS = 2;
   localparam int SHARED_SRCS  = 2 * SHARED_PAIRS;

   localparam logic [ADDR_W-1:0] A_REQ = 3'd0;
   localparam logic [ADDR_W-1:0] A_ENA = 3'd1;
   localparam logic [ADDR_W-1:0] A_VLD = 3'd2;
   localparam logic [ADDR_W-1:0] A_DSC = 3'd3;
   localparam logic [ADDR_W-1:0] A_CFG = 3'd4;
endpackage

// File: rtl/irqc_sync_edge.sv
// Two-flop synchronizer followed by a per-bit selectable edge detector.
module irqc_sync_edge #(
   parameter int   W    = 1,
   parameter logic IDLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   input  logic [W-1:0] rise_i,
   output logic [W-1:0] evt_o
);
   logic [W-1:0] s1_q, s2_q, prev_q;

   if (W < 1) begin : g_bad_w
      $error("irqc_sync_edge: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q   <= {W{IDLE}};
         s2_q   <= {W{IDLE}};
         prev_q <= {W{IDLE}};
      end else begin
         s1_q   <= pin_i;
         s2_q   <= s1_q;
         prev_q <= s2_q;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign evt_o[i] = rise_i[i] ? (s2_q[i] & ~prev_q[i])
                                  : (~s2_q[i] & prev_q[i]);
   end
endmodule

// File: rtl/irqc_pair.sv
// Sources sharing one request bit: each gated by its own valid bit,
// each with an ungated discrimination set.
module irqc_pair #(
   parameter int N_SRC = 2
) (
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] valid_i,
   output logic             req_set_o,
   output logic [N_SRC-1:0] disc_set_o
);
   if (N_SRC < 1) begin : g_bad_n
      $error("irqc_pair: N_SRC must be at least 1");
   end

   assign req_set_o  = |(evt_i & valid_i);
   assign disc_set_o = evt_i;
endmodule

// File: rtl/irqc_prio.sv
// Fixed priority: the lowest index wins.
module irqc_prio #(
   parameter  int N  = 4,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  pend_i,
   output logic          any_o,
   output logic [IW-1:0] id_o,
   output logic [N-1:0]  oh_o
);
   if (N < 2) begin : g_bad_n
      $error("irqc_prio: N must be at least 2");
   end

   always_comb begin
      any_o = 1'b0;
      id_o  = '0;
      oh_o  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            any_o = 1'b1;
            id_o  = IW'(i);
            oh_o  = '0;
            oh_o[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
   import irqc_pkg::*;
#(
   parameter  int N_EXT  = 2,
   parameter  int N_KEY  = 3,
   parameter  int DATA_W = 8,
   localparam int N_REQ  = N_EXT + SHARED_PAIRS,
   localparam int ID_W   = $clog2(N_REQ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EXT-1:0]  ext_pin_i,
   input  logic [N_KEY-1:0]  key_pin_i,
   input  logic              col_evt_i,
   input  logic              adc_evt_i,
   input  logic              tmr_evt_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              ack_i,
   input  logic              brk_i,
   input  logic              rti_i,
   input  logic              rti_flag_i,
   input  logic              sei_i,
   input  logic              cli_i,
   output logic              irq_o,
   output logic [ID_W-1:0]   irq_id_o,
   output logic              iflag_o
);
   localparam int CFG_W = N_EXT + N_KEY;

   if (CFG_W > DATA_W) begin : g_bad_cfg
      $error("irq_accept_ctrl: edge and key fields exceed DATA_W");
   end
   if (N_REQ > DATA_W || SHARED_SRCS > DATA_W) begin : g_bad_req
      $error("irq_accept_ctrl: request vector exceeds DATA_W");
   end
   if (N_EXT < 1 || N_KEY < 1) begin : g_bad_cnt
      $error("irq_accept_ctrl: N_EXT and N_KEY must be at least 1");
   end

   // state
   logic [N_REQ-1:0]       req_q, ena_q;
   logic [SHARED_SRCS-1:0] vld_q, dsc_q;
   logic [N_EXT-1:0]       edge_q;
   logic [N_KEY-1:0]       key_en_q;
   logic                   iflag_q;

   // event front end
   logic [N_EXT-1:0]        ext_evt;
   logic [N_KEY-1:0]        key_evt;
   logic                    kw_evt;
   logic [SHARED_SRCS-1:0]  sh_evt;
   logic [SHARED_PAIRS-1:0] pair_set;
   logic [SHARED_SRCS-1:0]  dsc_set;
   logic [N_REQ-1:0]        set_vec;

   irqc_sync_edge #(.W(N_EXT), .IDLE(1'b1)) u_ext (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_pin_i),
      .rise_i (edge_q),
      .evt_o  (ext_evt)
   );

   irqc_sync_edge #(.W(N_KEY), .IDLE(1'b1)) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (key_pin_i),
      .rise_i ({N_KEY{1'b0}}),
      .evt_o  (key_evt)
   );

   assign kw_evt = |(key_evt & key_en_q);
   assign sh_evt = {tmr_evt_i, adc_evt_i, col_evt_i, kw_evt};

   for (genvar p = 0; p < SHARED_PAIRS; p++) begin : g_pair
      irqc_pair #(.N_SRC(2)) u_pair (
         .evt_i      (sh_evt[2*p +: 2]),
         .valid_i    (vld_q[2*p +: 2]),
         .req_set_o  (pair_set[p]),
         .disc_set_o (dsc_set[2*p +: 2])
      );
   end

   assign set_vec = {pair_set, ext_evt};

   // selection
   logic             pend_any;
   logic [ID_W-1:0]  sel_id;
   logic [N_REQ-1:0] sel_oh;

   irqc_prio #(.N(N_REQ)) u_prio (
      .pend_i (req_q & ena_q),
      .any_o  (pend_any),
      .id_o   (sel_id),
      .oh_o   (sel_oh)
   );

   logic take;
   assign irq_o    = pend_any & ~iflag_q;
   assign irq_id_o = sel_id;
   assign iflag_o  = iflag_q;
   assign take     = ack_i & irq_o;

   // register writes
   logic wr_req, wr_ena, wr_vld, wr_dsc, wr_cfg;
   assign wr_req = reg_we_i && (reg_addr_i == A_REQ);
   assign wr_ena = reg_we_i && (reg_addr_i == A_ENA);
   assign wr_vld = reg_we_i && (reg_addr_i == A_VLD);
   assign wr_dsc = reg_we_i && (reg_addr_i == A_DSC);
   assign wr_cfg = reg_we_i && (reg_addr_i == A_CFG);

   logic [N_REQ-1:0]       req_d;
   logic [SHARED_SRCS-1:0] dsc_d;
   logic                   iflag_d;

   // order: software clear, then acceptance clear, then hardware set wins
   always_comb begin
      req_d = req_q;
      if (wr_req) req_d = req_d & reg_wdata_i[N_REQ-1:0];
      if (take)   req_d = req_d & ~sel_oh;
      req_d = req_d | set_vec;
   end

   always_comb begin
      dsc_d = dsc_q;
      if (wr_dsc) dsc_d = dsc_d & reg_wdata_i[SHARED_SRCS-1:0];
      dsc_d = dsc_d | dsc_set;
   end

   always_comb begin
      iflag_d = iflag_q;
      if (take || brk_i) iflag_d = 1'b1;
      else if (rti_i)    iflag_d = rti_flag_i;
      else if (sei_i)    iflag_d = 1'b1;
      else if (cli_i)    iflag_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q    <= '0;
         ena_q    <= '0;
         vld_q    <= '0;
         dsc_q    <= '0;
         edge_q   <= '0;
         key_en_q <= '0;
         iflag_q  <= 1'b1;
      end else begin
         req_q   <= req_d;
         dsc_q   <= dsc_d;
         iflag_q <= iflag_d;
         if (wr_ena) ena_q <= reg_wdata_i[N_REQ-1:0];
         if (wr_vld) vld_q <= reg_wdata_i[SHARED_SRCS-1:0];
         if (wr_cfg) begin
            edge_q   <= reg_wdata_i[N_EXT-1:0];
            key_en_q <= reg_wdata_i[N_EXT +: N_KEY];
         end
      end
   end

   always_comb begin
      case (reg_addr_i)
         A_REQ:   reg_rdata_o = DATA_W'(req_q);
         A_ENA:   reg_rdata_o = DATA_W'(ena_q);
         A_VLD:   reg_rdata_o = DATA_W'(vld_q);
         A_DSC:   reg_rdata_o = DATA_W'(dsc_q);
         A_CFG:   reg_rdata_o = DATA_W'({key_en_q, edge_q});
         default: reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk #(
   parameter int N_REQ = 4,
   parameter int ID_W  = 2,
   parameter int N_SH  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_i,
   input logic             brk_i,
   input logic             rti_i,
   input logic             rti_flag_i,
   input logic             irq_o,
   input logic [ID_W-1:0]  irq_id_o,
   input logic             iflag_o,
   input logic [N_REQ-1:0] req_q,
   input logic [N_REQ-1:0] set_vec,
   input logic [N_SH-1:0]  dsc_q,
   input logic [N_SH-1:0]  dsc_set
);
   // R4
   req_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_q & ~$past(req_q) & ~$past(set_vec)) == '0));

   // R7
   dsc_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dsc_q & ~$past(dsc_q) & ~$past(dsc_set)) == '0));

   // R3
   ack_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> iflag_o);

   // R3
   ack_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && !set_vec[irq_id_o]) |=> !req_q[$past(irq_id_o)]);

   // R10
   brk_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_i |=> iflag_o);

   // R10
   rti_loads_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_i && !ack_i && !brk_i) |=> (iflag_o == $past(rti_flag_i)));
endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(
   .N_REQ (N_REQ),
   .ID_W  (ID_W),
   .N_SH  (irqc_pkg::SHARED_SRCS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack_i      (ack_i),
   .brk_i      (brk_i),
   .rti_i      (rti_i),
   .rti_flag_i (rti_flag_i),
   .irq_o      (irq_o),
   .irq_id_o   (irq_id_o),
   .iflag_o    (iflag_o),
   .req_q      (req_q),
   .set_vec    (set_vec),
   .dsc_q      (dsc_q),
   .dsc_set    (dsc_set)
);

// File: tb/irq_accept_ctrl_test.sv
module irq_accept_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_pin = 2'b11;
   logic [2:0] key_pin = 3'b111;
   logic       col_evt = 0, adc_evt = 0, tmr_evt = 0;
   logic       reg_we = 0;
   logic [2:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic       ack = 0, brk = 0, rti = 0, rti_flag = 0, sei = 0, cli = 0;
   logic       irq;
   logic [1:0] irq_id;
   logic       iflag;

   int checks = 0;
   int fails  = 0;
   logic mon_go = 1'b0;
   int         kind_q[$];
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   irq_accept_ctrl uut (
      .clk (clk), .rst_n (rst_n),
      .ext_pin_i (ext_pin), .key_pin_i (key_pin),
      .col_evt_i (col_evt), .adc_evt_i (adc_evt), .tmr_evt_i (tmr_evt),
      .reg_we_i (reg_we), .reg_addr_i (reg_addr),
      .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
      .ack_i (ack), .brk_i (brk), .rti_i (rti), .rti_flag_i (rti_flag),
      .sei_i (sei), .cli_i (cli),
      .irq_o (irq), .irq_id_o (irq_id), .iflag_o (iflag)
   );

   // monitor: pops the expected item and compares mid-cycle
   always @(negedge clk) begin
      if (mon_go && kind_q.size() > 0) begin
         int         k;
         logic [7:0] e, a;
         string      t;
         k = kind_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = (k == 1) ? {4'b0, irq, irq_id, iflag} : reg_rdata;
         checks++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, a, e);
         end
      end
   end

   task automatic step(int n = 1);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 0;
   endtask

   task automatic exp_reg(logic [2:0] a, logic [7:0] e, string t);
      reg_addr = a;
      kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
      mon_go = 1;
      step();
      mon_go = 0;
   endtask

   // packed {irq, id[1:0], iflag}
   task automatic exp_irq(logic i, logic [1:0] id, logic f, string t);
      kind_q.push_back(1); exp_q.push_back({4'b0, i, id, f}); tag_q.push_back(t);
      mon_go = 1;
      step();
      mon_go = 0;
   endtask

   bit done = 0;

   initial begin
      step(3);
      rst_n = 1;
      step();
      // R1 reset state
      exp_reg(0, 8'h00, "R1 req");
      exp_reg(1, 8'h00, "R1 ena");
      exp_reg(2, 8'h00, "R1 vld");
      exp_reg(3, 8'h00, "R1 dsc");
      exp_reg(4, 8'h00, "R1 cfg");
      exp_irq(0, 2'd0, 1, "R1 flag");
      cli = 1; step(); cli = 0;
      exp_irq(0, 2'd0, 0, "R10 cli");
      // R5 disabled source latches but does not interrupt
      wr(2, 8'h08);
      tmr_evt = 1; step(); tmr_evt = 0;
      exp_reg(0, 8'h08, "R5 req latched");
      exp_reg(3, 8'h08, "R7 dsc timer");
      exp_irq(0, 2'd0, 0, "R5 no irq");
      // R4 write-0-only
      wr(0, 8'hFF);
      exp_reg(0, 8'h08, "R4 write1 ignored");
      wr(0, 8'hF7);
      exp_reg(0, 8'h00, "R4 write0 clears");
      // R6 invalid shared source
      adc_evt = 1; step(); adc_evt = 0;
      exp_reg(0, 8'h00, "R6 invalid no req");
      exp_reg(3, 8'h0C, "R6 dsc set anyway");
      wr(3, 8'hFF);
      exp_reg(3, 8'h0C, "R7 write1 ignored");
      wr(3, 8'h00);
      exp_reg(3, 8'h00, "R7 write0 clears");
      // R8 edges
      wr(1, 8'h0F);
      ext_pin[0] = 0; step(5);
      exp_irq(1, 2'd0, 0, "R8 int0 falling");
      wr(4, 8'h02);
      ext_pin[1] = 0; step(5);
      exp_reg(0, 8'h01, "R8 int1 falling ignored");
      ext_pin[1] = 1; step(5);
      exp_reg(0, 8'h03, "R8 int1 rising");
      // R2/R3 priority and acceptance
      exp_irq(1, 2'd0, 0, "R2 lowest wins");
      ack = 1; step(); ack = 0;
      exp_irq(0, 2'd1, 1, "R3 flag set after ack");
      exp_reg(0, 8'h02, "R3 only selected cleared");
      rti = 1; rti_flag = 0; step(); rti = 0;
      exp_irq(1, 2'd1, 0, "R10 rti restores");
      ack = 1; step(); ack = 0;
      exp_reg(0, 8'h00, "R3 second ack");
      exp_irq(0, 2'd0, 1, "R3 flag after second ack");
      // R10 break
      cli = 1; step(); cli = 0;
      exp_irq(0, 2'd0, 0, "R10 cli again");
      brk = 1; step(); brk = 0;
      exp_irq(0, 2'd0, 1, "R10 brk sets flag");
      // R9 key wakeup, only pin 1 enabled
      wr(4, 8'h0A);
      wr(2, 8'h01);
      key_pin[0] = 0; step(5);
      exp_reg(0, 8'h00, "R9 disabled key pin");
      exp_reg(3, 8'h00, "R9 disabled key pin dsc");
      key_pin[1] = 0; step(5);
      exp_reg(0, 8'h04, "R9 key wakeup req");
      exp_reg(3, 8'h01, "R9 key wakeup dsc");
      col_evt = 1; step(); col_evt = 0;
      exp_reg(3, 8'h03, "R6 collision dsc only");
      exp_reg(0, 8'h04, "R6 collision invalid");
      // R2 mask by flag
      exp_irq(0, 2'd2, 1, "R2 masked by flag");
      cli = 1; step(); cli = 0;
      exp_irq(1, 2'd2, 0, "R2 unmasked");
      // R11 set beats clear
      wr(2, 8'h09);
      reg_we = 1; reg_addr = 0; reg_wdata = 8'h00; tmr_evt = 1;
      step();
      reg_we = 0; tmr_evt = 0;
      exp_reg(0, 8'h08, "R11 set wins");
      sei = 1; step(); sei = 0;
      exp_irq(0, 2'd3, 1, "R10 sei");
      step(2);
      if (kind_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: %0d items left, expected 0", kind_q.size());
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule